// File: doc/BRIEF.md
# Chained XOR/Copy Descriptor Engine

One channel of a memory offload engine. Software builds a linked list of descriptors in memory, points the channel at the first one and activates it. For each descriptor the channel reads the enabled source buffers one 32-bit word at a time. It XORs the words of the same index together, starting from zero, and writes the result to the destination buffer. In copy operation it moves the first source unchanged. When a descriptor is finished the channel writes a success status into it. It then follows the descriptor's next pointer, and a next pointer of zero ends the walk.

Control goes through a small register port. It holds the operation mode, the next-descriptor pointer, an activation register that also reports the channel state, and a read-only copy of the current descriptor address. Memory is reached through a single-outstanding word request/acknowledge master. Three single-cycle event pulses go to an interrupt block: descriptor done, chain done, and stopped on error. Once the channel is idle or stopped, software may write a new next pointer and activate it again. The walk then resumes from that descriptor, which lets a chain be extended after it has run out.

Top module: `xor_chain_engine`

## Requirements
- R1: After reset every register reads zero. Register addresses are 0 = mode, 1 = next pointer, 2 = activation/state, 3 = current descriptor. The mode register keeps and returns bits [2:0].
- R2: Writing the activation register with bit 0 = 1 while the channel is idle or stopped starts it at the address held in the next-pointer register. The state field, bits [5:4] of register 2, reads 1 from the following cycle until the walk ends. A write with bit 0 = 0 has no effect.
- R3: Descriptor word offsets are 0 status, 1 command, 2 byte count, 3 destination, 4 next pointer, and 5..12 sources 0..7.
- R4: In XOR operation (mode 0), destination word k is the XOR of word k of every source i whose command bit i is set. With no source enabled the word is zero.
- R5: In copy operation (mode 1), destination word k equals word k of source 0, whatever the command bitmap holds.
- R6: In descriptor mode (mode 2), command bits [26:24] choose the operation: 1 = copy, any other value = XOR.
- R7: After its last destination word, a descriptor's status word is overwritten with 0x4000_0000 (success bit 30 set, engine-owned bit 31 clear).
- R8: A descriptor-done pulse follows a completed descriptor only if its command bit 31 is set.
- R9: A non-zero next pointer is followed. A zero next pointer ends the walk with a chain-done pulse, state 0, and register 3 holding the last descriptor address.
- R10: A byte count below 16 stops the channel. A stopped pulse is raised, state reads 2, and nothing is written for that descriptor. A later activation restarts the channel.
- R11: After the channel goes idle, a newly written next pointer plus activation processes the descriptor at that pointer.
- R12: The number of destination words is the byte count divided by 4, rounded up. The word after the last one is left untouched.
- R13: A memory request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| eod_o | output | 1 | Descriptor-done pulse |
| eoc_o | output | 1 | Chain-done pulse |
| stop_o | output | 1 | Stopped-on-error pulse |

## Verification
The combine path is driven with several bitmaps. The all-sources bitmap exposes any dropped or duplicated source. The empty bitmap must produce zero words. Sparse bitmaps catch a wrong source picked by position. The same sparse bitmap is also run under copy mode and under descriptor-selected operations, so a result that ignores the mode cannot pass. Byte counts that are not multiples of four, the exact minimum of 16, and 12 (below the minimum) test the word-count rounding and the error stop. Randomised chains with random memory latency, random mode and random interrupt bits are followed by directed restarts after a stop and after the chain ran out.

// File: rtl/xce_pkg.sv
package xce_pkg;
  localparam int XW = 32;

  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_CHECK, C_SRC, C_DST, C_STAT, C_HALT
  } ctl_e;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_BUSY = 2'd1;
  localparam logic [1:0] ST_HALT = 2'd2;

  localparam logic [2:0] MODE_XOR  = 3'd0;
  localparam logic [2:0] MODE_COPY = 3'd1;
  localparam logic [2:0] MODE_DESC = 3'd2;
  localparam logic [2:0] OP_COPY   = 3'd1;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_NEXT = 2'd1;
  localparam logic [1:0] RA_ACT  = 2'd2;
  localparam logic [1:0] RA_CUR  = 2'd3;

  localparam logic [XW-1:0] STATUS_DONE = 32'h4000_0000;
  localparam int CMD_IRQ_BIT = 31;
  localparam int CMD_OP_LSB  = 24;

  // descriptor word offsets
  localparam int DW_CMD  = 1;
  localparam int DW_CNT  = 2;
  localparam int DW_DST  = 3;
  localparam int DW_NXT  = 4;
  localparam int DW_SRC0 = 5;
endpackage

// File: rtl/xce_regs.sv
module xce_regs
  import xce_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [XW-1:0] reg_wdata_i,
  output logic [XW-1:0] reg_rdata_o,
  input  logic [1:0]    state_i,
  input  logic [XW-1:0] cur_i,
  output logic [2:0]    mode_o,
  output logic [XW-1:0] next_o,
  output logic          start_o
);
  logic [2:0]    mode_q;
  logic [XW-1:0] next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      next_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == RA_CFG)  mode_q <= reg_wdata_i[2:0];
      if (reg_addr_i == RA_NEXT) next_q <= reg_wdata_i;
    end
  end

  assign start_o = reg_we_i && (reg_addr_i == RA_ACT) && reg_wdata_i[0];
  assign mode_o  = mode_q;
  assign next_o  = next_q;

  always_comb begin
    case (reg_addr_i)
      RA_CFG:  reg_rdata_o = {{(XW-3){1'b0}}, mode_q};
      RA_NEXT: reg_rdata_o = next_q;
      RA_ACT:  reg_rdata_o = {{(XW-6){1'b0}}, state_i, 4'b0000};
      default: reg_rdata_o = cur_i;
    endcase
  end
endmodule

// File: rtl/xce_src_pick.sv
module xce_src_pick #(
  parameter int NSRC = 8,
  localparam int LW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pending_i,
  output logic [LW-1:0]   idx_o,
  output logic            any_o
);
  logic [NSRC-1:0] first;

  // lowest pending source wins
  for (genvar i = 0; i < NSRC; i++) begin : g_first
    if (i == 0) begin : g_lo
      assign first[i] = pending_i[i];
    end else begin : g_hi
      assign first[i] = pending_i[i] & ~|pending_i[i-1:0];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (first[i]) idx_o = idx_o | LW'(i);
  end

  assign any_o = |pending_i;

  // R4
  always_comb begin
    if (any_o) begin
      pick_hit_chk: assert (pending_i[idx_o] && ((pending_i & ((NSRC)'(1) << idx_o) - 1'b1) == '0));
    end
  end
endmodule

// File: rtl/xce_ctrl.sv
module xce_ctrl
  import xce_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int CNT_W     = 24,
  parameter int MIN_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [XW-1:0] next_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [XW-1:0] mem_addr_o,
  output logic [XW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [XW-1:0] mem_rdata_i,
  output logic [1:0]    state_o,
  output logic [XW-1:0] cur_o,
  output logic          eod_o,
  output logic          eoc_o,
  output logic          stop_o
);
  localparam int DESC_WORDS = DW_SRC0 + NSRC;
  localparam int FW = $clog2(DESC_WORDS);
  localparam int LW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW = CNT_W;

  ctl_e            cs;
  logic [XW-1:0]   cur_q, dst_q, nxt_q;
  logic [XW-1:0]   src_q [NSRC];
  logic [FW-1:0]   fidx_q;
  logic [NSRC-1:0] cmd_en_q, en_q, pend_q;
  logic [2:0]      cmd_op_q;
  logic            cmd_irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CW-1:0]   wk_q, nwords_q;
  logic [XW-1:0]   acc_q;
  logic            eod_q, eoc_q, stop_q;

  logic [LW-1:0]   pick_idx;
  logic            pick_any;
  logic            copy_op;
  logic [NSRC-1:0] en_c;
  logic [CW-1:0]   nw_c;
  logic [XW-1:0]   woff;

  xce_src_pick #(.NSRC(NSRC)) u_pick (
    .pending_i (pend_q),
    .idx_o     (pick_idx),
    .any_o     (pick_any)
  );

  assign copy_op = (mode_i == MODE_COPY) ||
                   ((mode_i == MODE_DESC) && (cmd_op_q == OP_COPY));
  assign en_c    = copy_op ? NSRC'(1) : cmd_en_q;
  assign nw_c    = CW'(({1'b0, cnt_q} + (CNT_W+1)'(3)) >> 2);
  assign woff    = XW'({wk_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs        <= C_IDLE;
      cur_q     <= '0;
      dst_q     <= '0;
      nxt_q     <= '0;
      for (int s = 0; s < NSRC; s++) src_q[s] <= '0;
      fidx_q    <= '0;
      cmd_en_q  <= '0;
      cmd_op_q  <= '0;
      cmd_irq_q <= 1'b0;
      cnt_q     <= '0;
      en_q      <= '0;
      pend_q    <= '0;
      wk_q      <= '0;
      nwords_q  <= '0;
      acc_q     <= '0;
      eod_q     <= 1'b0;
      eoc_q     <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      eod_q  <= 1'b0;
      eoc_q  <= 1'b0;
      stop_q <= 1'b0;
      case (cs)
        C_IDLE, C_HALT: begin
          if (start_i) begin
            cur_q  <= next_i;
            fidx_q <= FW'(DW_CMD);
            cs     <= C_FETCH;
          end
        end
        C_FETCH: begin
          if (mem_ack_i) begin
            if (fidx_q == FW'(DW_CMD)) begin
              cmd_en_q  <= mem_rdata_i[NSRC-1:0];
              cmd_op_q  <= mem_rdata_i[CMD_OP_LSB +: 3];
              cmd_irq_q <= mem_rdata_i[CMD_IRQ_BIT];
            end
            if (fidx_q == FW'(DW_CNT)) cnt_q <= mem_rdata_i[CNT_W-1:0];
            if (fidx_q == FW'(DW_DST)) dst_q <= mem_rdata_i;
            if (fidx_q == FW'(DW_NXT)) nxt_q <= mem_rdata_i;
            for (int s = 0; s < NSRC; s++)
              if (fidx_q == FW'(DW_SRC0 + s)) src_q[s] <= mem_rdata_i;
            if (fidx_q == FW'(DESC_WORDS - 1)) cs <= C_CHECK;
            else fidx_q <= fidx_q + 1'b1;
          end
        end
        C_CHECK: begin
          if (cnt_q < CNT_W'(MIN_BYTES)) begin
            stop_q <= 1'b1;
            cs     <= C_HALT;
          end else begin
            en_q     <= en_c;
            pend_q   <= en_c;
            wk_q     <= '0;
            nwords_q <= nw_c;
            acc_q    <= '0;
            cs       <= C_SRC;
          end
        end
        C_SRC: begin
          if (!pick_any) cs <= C_DST;
          else if (mem_ack_i) begin
            acc_q            <= acc_q ^ mem_rdata_i;
            pend_q[pick_idx] <= 1'b0;
          end
        end
        C_DST: begin
          if (mem_ack_i) begin
            if (wk_q == nwords_q - 1'b1) cs <= C_STAT;
            else begin
              wk_q   <= wk_q + 1'b1;
              acc_q  <= '0;
              pend_q <= en_q;
              cs     <= C_SRC;
            end
          end
        end
        C_STAT: begin
          if (mem_ack_i) begin
            eod_q <= cmd_irq_q;
            if (nxt_q == '0) begin
              eoc_q <= 1'b1;
              cs    <= C_IDLE;
            end else begin
              cur_q  <= nxt_q;
              fidx_q <= FW'(DW_CMD);
              cs     <= C_FETCH;
            end
          end
        end
        default: cs <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (cs)
      C_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + XW'({fidx_q, 2'b00});
      end
      C_SRC: begin
        mem_req_o  = pick_any;
        mem_addr_o = src_q[pick_idx] + woff;
      end
      C_DST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_q + woff;
        mem_wdata_o = acc_q;
      end
      C_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q;
        mem_wdata_o = STATUS_DONE;
      end
      default: ;
    endcase
  end

  assign state_o = (cs == C_IDLE) ? ST_IDLE : (cs == C_HALT) ? ST_HALT : ST_BUSY;
  assign cur_o   = cur_q;
  assign eod_o   = eod_q;
  assign eoc_o   = eoc_q;
  assign stop_o  = stop_q;

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_BUSY) && start_i |=> state_o == ST_BUSY);
  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R9
  eoc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> state_o == ST_IDLE);
  // R10
  stop_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> state_o == ST_HALT && !mem_req_o);
  // R10
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != ST_BUSY |-> !mem_req_o);
  // R9
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eoc_o, stop_o}));
endmodule

// File: rtl/xor_chain_engine.sv
module xor_chain_engine
  import xce_pkg::*;
#(
  parameter int NSRC      = 8,
  parameter int CNT_W     = 24,
  parameter int MIN_BYTES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        eod_o,
  output logic        eoc_o,
  output logic        stop_o
);
  logic [1:0]    state;
  logic [XW-1:0] cur, next_ptr;
  logic [2:0]    mode;
  logic          start;

  xce_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .state_i     (state),
    .cur_i       (cur),
    .mode_o      (mode),
    .next_o      (next_ptr),
    .start_o     (start)
  );

  xce_ctrl #(.NSRC(NSRC), .CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .mode_i      (mode),
    .next_i      (next_ptr),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .state_o     (state),
    .cur_o       (cur),
    .eod_o       (eod_o),
    .eoc_o       (eoc_o),
    .stop_o      (stop_o)
  );
endmodule

// File: tb/xor_chain_engine_bench.sv
`timescale 1ns/1ps
module xor_chain_engine_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        eod, eoc, stop;

  always #2 clk = ~clk;

  xor_chain_engine u_xor_chain_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .eod_o(eod), .eoc_o(eoc), .stop_o(stop)
  );

  logic [31:0] mem [2048];
  int wait_cnt = 0;
  int checks = 0, errors = 0;
  int n_eod = 0, n_eoc = 0, n_stop = 0;
  int d_cmd [16];
  int d_cnt [16];
  bit d_copy [16];

  // memory model with random latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[12:2]];
        wait_cnt <= $urandom % 3;
      end else wait_cnt <= wait_cnt - 1;
    end
  end

  always @(posedge clk) if (rst_n) begin
    if (eod) n_eod <= n_eod + 1;
    if (eoc) n_eoc <= n_eoc + 1;
    if (stop) n_stop <= n_stop + 1;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  function automatic int daddr(int di); return 32'h40 + di * 64; endfunction
  function automatic int dst_addr(int di); return 32'h1000 + di * 32'h100; endfunction
  function automatic int src_addr(int s); return 32'h800 + s * 32'h80; endfunction

  task automatic fill_src();
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 32; k++) mem[(src_addr(s) >> 2) + k] = $urandom;
  endtask

  // cmd: [7:0] source enables, [26:24] op, [31] irq
  task automatic put_desc(int di, int cmd, int cnt, int nxt, int mode);
    int b = daddr(di) >> 2;
    mem[b + 0] = 32'h8000_0000;
    mem[b + 1] = cmd;
    mem[b + 2] = cnt;
    mem[b + 3] = dst_addr(di);
    mem[b + 4] = nxt;
    for (int s = 0; s < 8; s++) mem[b + 5 + s] = src_addr(s);
    for (int k = 0; k < 64; k++) mem[(dst_addr(di) >> 2) + k] = 32'hDEAD_BEEF;
    d_cmd[di] = cmd; d_cnt[di] = cnt;
    d_copy[di] = (mode == 1) || (mode == 2 && ((cmd >> 24) & 7) == 1);
  endtask

  function automatic logic [31:0] exp_word(int di, int k);
    logic [31:0] r = 0;
    if (d_copy[di]) return mem[(src_addr(0) >> 2) + k];
    for (int s = 0; s < 8; s++)
      if (d_cmd[di][s]) r ^= mem[(src_addr(s) >> 2) + k];
    return r;
  endfunction

  task automatic check_desc(int di, string req);
    int words = (d_cnt[di] + 3) / 4;
    int bad = -1;
    logic [31:0] a = 0, e = 0;
    for (int k = 0; k < words; k++) begin
      if (bad < 0 && mem[(dst_addr(di) >> 2) + k] !== exp_word(di, k)) begin
        bad = k; a = mem[(dst_addr(di) >> 2) + k]; e = exp_word(di, k);
      end
    end
    chk(bad < 0, {req, " dest data"}, a, e);
    chk(mem[(dst_addr(di) >> 2) + words] === 32'hDEAD_BEEF, "R12 guard word", mem[(dst_addr(di) >> 2) + words], 32'hDEAD_BEEF);
    chk(mem[daddr(di) >> 2] === 32'h4000_0000, "R7 status", mem[daddr(di) >> 2], 32'h4000_0000);
  endtask

  task automatic wait_end();
    int e0 = n_eoc, s0 = n_stop, t = 0;
    while (n_eoc == e0 && n_stop == s0 && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, "R9 walk timeout", t, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(int mode, int first);
    logic [31:0] v;
    reg_wr(2'd0, mode);
    reg_wr(2'd1, daddr(first));
    reg_wr(2'd2, 32'h1);
    reg_rd(2'd2, v);
    chk(v[5:4] == 2'd1, "R2 busy after start", v[5:4], 1);
  endtask

  task automatic end_state(int last, int eod0, int eod_exp, int eoc0);
    logic [31:0] v;
    reg_rd(2'd2, v);
    chk(v[5:4] == 2'd0, "R9 idle at end", v[5:4], 0);
    reg_rd(2'd3, v);
    chk(v == daddr(last), "R9 current pointer", v, daddr(last));
    chk(n_eoc == eoc0 + 1, "R9 chain-done pulse", n_eoc - eoc0, 1);
    chk(n_eod - eod0 == eod_exp, "R8 descriptor-done pulses", n_eod - eod0, eod_exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e0, c0, s0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    reg_wr(2'd0, 32'hFFFF_FFFA);
    reg_rd(2'd0, v);
    chk(v == 32'h2, "R1 mode readback", v, 2);

    // R2 activation with bit 0 clear
    reg_wr(2'd2, 32'hFFFF_FFFE);
    repeat (4) @(negedge clk);
    reg_rd(2'd2, v);
    chk(v[5:4] == 0, "R2 bit0=0 ignored", v[5:4], 0);
    chk(n_eoc == 0 && n_stop == 0, "R2 no walk", n_eoc + n_stop, 0);

    fill_src();

    // R4 all sources, R7/R8
    put_desc(0, 32'h8000_00FF, 32, 0, 0);
    e0 = n_eod; c0 = n_eoc;
    launch(0, 0); wait_end();
    check_desc(0, "R4 all sources");
    end_state(0, e0, 1, c0);

    // R3 R9 R12 chain of three, irq on first and last
    put_desc(1, 32'h8000_0005, 18, daddr(2), 0);
    put_desc(2, 32'h0000_0000, 16, daddr(3), 0);
    put_desc(3, 32'h8000_00A6, 40, 0, 0);
    e0 = n_eod; c0 = n_eoc;
    launch(0, 1); wait_end();
    check_desc(1, "R4 sparse bitmap");
    check_desc(2, "R4 empty bitmap");
    check_desc(3, "R3 chain tail");
    end_state(3, e0, 2, c0);

    // R5 copy ignores bitmap
    put_desc(4, 32'h0000_00F0, 24, 0, 1);
    e0 = n_eod; c0 = n_eoc;
    launch(1, 4); wait_end();
    check_desc(4, "R5 copy");
    end_state(4, e0, 0, c0);

    // R6 op from descriptor
    put_desc(5, 32'h0100_000E, 20, daddr(6), 2);
    put_desc(6, 32'h0000_000E, 20, 0, 2);
    e0 = n_eod; c0 = n_eoc;
    launch(2, 5); wait_end();
    check_desc(5, "R6 descriptor copy");
    check_desc(6, "R6 descriptor xor");
    end_state(6, e0, 0, c0);

    // R10 short byte count
    put_desc(7, 32'h8000_0003, 12, 0, 0);
    s0 = n_stop; c0 = n_eoc; e0 = n_eod;
    launch(0, 7); wait_end();
    chk(n_stop == s0 + 1, "R10 stop pulse", n_stop - s0, 1);
    reg_rd(2'd2, v);
    chk(v[5:4] == 2'd2, "R10 halted state", v[5:4], 2);
    chk(mem[daddr(7) >> 2] == 32'h8000_0000, "R10 status untouched", mem[daddr(7) >> 2], 32'h8000_0000);
    chk(mem[dst_addr(7) >> 2] == 32'hDEAD_BEEF, "R10 dest untouched", mem[dst_addr(7) >> 2], 32'hDEAD_BEEF);
    chk(n_eoc == c0 && n_eod == e0, "R10 no done pulses", n_eoc - c0 + n_eod - e0, 0);

    // R10 restart after stop
    put_desc(8, 32'h8000_0011, 16, 0, 0);
    e0 = n_eod; c0 = n_eoc;
    launch(0, 8); wait_end();
    check_desc(8, "R10 restart");
    end_state(8, e0, 1, c0);

    // R11 extend a finished chain
    put_desc(9, 32'h0000_0042, 28, daddr(10), 0);
    put_desc(10, 32'h8000_0081, 32, 0, 0);
    e0 = n_eod; c0 = n_eoc;
    reg_wr(2'd1, daddr(9));
    reg_wr(2'd2, 32'h1);
    wait_end();
    check_desc(9, "R11 resumed chain");
    check_desc(10, "R11 resumed tail");
    end_state(10, e0, 1, c0);

    // random chains
    for (int it = 0; it < 6; it++) begin
      int len = 1 + $urandom % 3;
      int mode = $urandom % 3;
      int ne = 0;
      fill_src();
      for (int j = 0; j < len; j++) begin
        int cmd = ($urandom % 256) | (($urandom % 2) << 24) | (($urandom % 2) << 31);
        int cnt = 16 + $urandom % 85;
        if (cmd[31]) ne++;
        put_desc(11 + j, cmd, cnt, (j == len - 1) ? 0 : daddr(12 + j), mode);
      end
      e0 = n_eod; c0 = n_eoc;
      launch(mode, 11); wait_end();
      for (int j = 0; j < len; j++) check_desc(11 + j, "R4 R5 R6 random");
      end_state(11 + len - 1, e0, ne, c0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule